// File: doc/BRIEF.md
# Bit-Test Conditional Skip Unit

This unit executes the two single-bit conditional skip operations of an 8-bit controller core. An accepted operation word names one bit of a data-memory byte and a polarity. The unit reads that byte and tests the bit. When the bit equals the polarity, the unit discards the instruction that was already prefetched and inserts idle cycles in its place. Each instruction cycle is made of four clock phases. The unit publishes the current phase, so the core around it can see exactly where the operation stands.

The data address comes from one of three sources. The first is an access window that splits the 8-bit field between the lowest and highest banks. The second is a bank register placed in front of the field. The third, used when an extended mode is on, is an index pointer plus the field treated as a literal offset. The unit drives the address and a read strobe toward the register file and takes back one byte. It checks whether the prefetched word begins a two-word instruction, because that sets how many idle cycles a taken skip costs. When the operation finishes, the unit reports the next program counter, whether the skip was taken, and how many instruction cycles were spent.

Top module: `bitskip_unit`

## Requirements
- R1: An operation is accepted on `start` only when `instr_word[15:12]` is 1011 (skip when the bit is clear) or 1010 (skip when the bit is set). Any other value leaves `busy`, `rd_en` and `done` low. Field layout: bits 11:9 select the bit, bit 8 selects banked mode, and bits 7:0 hold the file field f.
- R2: The skip is taken when the tested bit is 0 for the clear form and when it is 1 for the set form. `skip_taken` reports the decision when `done` is high.
- R3: When bit 8 is 1, the read address is {bank_sel, f}, whether or not the extended mode is on.
- R4: When bit 8 is 0 and indexing does not apply, f in 0x00–0x5F reads 0x000+f and f in 0x60–0xFF reads 0xF00+f.
- R5: When bit 8 is 0, `ext_mode` is 1 and f ≤ 0x5F, the read address is (idx_ptr + f) modulo 4096.
- R6: `q_phase` counts 0,1,2,3 once per clock while busy. `rd_en` is high for exactly one clock per operation: the phase-1 clock of the execute cycle, which is the second clock after acceptance.
- R7: With no skip, `done` rises in the fourth clock after acceptance, with `pc_next` = pc_in+2, `cycles` = 1 and no `flush`.
- R8: On a taken skip over a one-word instruction, `flush` pulses in the fourth clock and one four-phase idle cycle follows. `done` then rises in the eighth clock, with `pc_next` = pc_in+4 and `cycles` = 2.
- R9: When `next_word & TW_MASK == TW_MATCH` (by default, top nibble 1111), a taken skip inserts two idle cycles. `done` then rises in the twelfth clock, with `pc_next` = pc_in+6 (modulo 2^PC_W) and `cycles` = 3.
- R10: A `start` pulse while `busy` is high is ignored. No second read or completion follows.
- R11: After reset, `busy`, `rd_en`, `flush` and `done` are 0 and `q_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Offer of an operation word for acceptance |
| instr_word | input | 16 | Operation word |
| next_word | input | 16 | Prefetched following word |
| pc_in | input | PC_W | Byte address of the operation |
| bank_sel | input | BANK_W | Bank register value |
| idx_ptr | input | BANK_W+8 | Index pointer for literal-offset mode |
| ext_mode | input | 1 | Extended addressing enable |
| rd_addr | output | BANK_W+8 | Data-memory read address |
| rd_en | output | 1 | Read strobe |
| rd_data | input | 8 | Byte returned in the same clock as the strobe |
| busy | output | 1 | Operation in progress |
| q_phase | output | 2 | Current phase within the instruction cycle |
| flush | output | 1 | Discard the prefetched instruction |
| done | output | 1 | Completion pulse |
| skip_taken | output | 1 | Skip decision, valid with done |
| pc_next | output | PC_W | Updated program counter, valid with done |
| cycles | output | 2 | Instruction cycles spent, valid with done |

## Verification
The hardest case to reach from the ports is a taken skip that needs two idle cycles while the operand is fetched through the index pointer. Here the wrong address, wrong bit or wrong prefix decode would change only the final timing. To reach it, the stimulus writes the addressed byte with the tested bit opposite to all seven others. It then pairs a literal-offset operand with a prefetched word carrying the two-word prefix, including a pointer sum that wraps past 4095. A second start pulse is also raised during an operation to show that it is not accepted.

// File: rtl/bitskip_pkg.sv
package bitskip_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_EXEC = 2'd1,
        SEQ_NOP  = 2'd2
    } seq_e;

    localparam logic [3:0] OPC_TEST_CLR = 4'b1011;
    localparam logic [3:0] OPC_TEST_SET = 4'b1010;

    localparam logic [1:0] PH_DECODE = 2'd0;
    localparam logic [1:0] PH_READ   = 2'd1;
    localparam logic [1:0] PH_PROC   = 2'd2;
    localparam logic [1:0] PH_LAST   = 2'd3;

endpackage

// File: rtl/bitskip_decode.sv
module bitskip_decode
    import bitskip_pkg::*;
#(
    parameter logic [15:0] TW_MASK  = 16'hF000,
    parameter logic [15:0] TW_MATCH = 16'hF000
) (
    input  logic [15:0] op_word,
    input  logic [15:0] follow_word,
    output logic        is_op,
    output logic        pol_set,
    output logic [2:0]  bit_sel,
    output logic        banked,
    output logic [7:0]  fsel,
    output logic        follow_two
);
    logic [3:0] opc;

    always_comb begin
        opc        = op_word[15:12];
        is_op      = (opc == OPC_TEST_CLR) || (opc == OPC_TEST_SET);
        pol_set    = (opc == OPC_TEST_SET);
        bit_sel    = op_word[11:9];
        banked     = op_word[8];
        fsel       = op_word[7:0];
        follow_two = ((follow_word & TW_MASK) == TW_MATCH);
    end
endmodule

// File: rtl/bitskip_addr.sv
module bitskip_addr #(
    parameter int         BANK_W    = 4,
    parameter logic [7:0] IDX_LIMIT = 8'h5F,
    localparam int        DADDR_W   = BANK_W + 8
) (
    input  logic [7:0]         fsel,
    input  logic               banked,
    input  logic               ext_on,
    input  logic [BANK_W-1:0]  bank,
    input  logic [DADDR_W-1:0] idx,
    output logic [DADDR_W-1:0] addr
);
    logic low_half;

    always_comb begin
        low_half = (fsel <= IDX_LIMIT);
        if (banked) begin
            addr = {bank, fsel};
        end else if (ext_on && low_half) begin
            addr = idx + {{BANK_W{1'b0}}, fsel};
        end else if (low_half) begin
            addr = {{BANK_W{1'b0}}, fsel};
        end else begin
            addr = {{BANK_W{1'b1}}, fsel};
        end
    end
endmodule

// File: rtl/bitskip_unit.sv
module bitskip_unit
    import bitskip_pkg::*;
#(
    parameter int          PC_W     = 21,
    parameter int          BANK_W   = 4,
    parameter logic [15:0] TW_MASK  = 16'hF000,
    parameter logic [15:0] TW_MATCH = 16'hF000,
    localparam int         DADDR_W  = BANK_W + 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [15:0]        instr_word,
    input  logic [15:0]        next_word,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [BANK_W-1:0]  bank_sel,
    input  logic [DADDR_W-1:0] idx_ptr,
    input  logic               ext_mode,
    output logic [DADDR_W-1:0] rd_addr,
    output logic               rd_en,
    input  logic [7:0]         rd_data,
    output logic               busy,
    output logic [1:0]         q_phase,
    output logic               flush,
    output logic               done,
    output logic               skip_taken,
    output logic [PC_W-1:0]    pc_next,
    output logic [1:0]         cycles
);
    localparam int WORD_BYTES = 2;
    localparam logic [PC_W-1:0] STEP1 = PC_W'(WORD_BYTES);
    localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * WORD_BYTES);
    localparam logic [PC_W-1:0] STEP3 = PC_W'(3 * WORD_BYTES);

    typedef struct packed {
        seq_e               st;
        logic [1:0]         ph;
        logic               pol;
        logic [2:0]         bsel;
        logic               banked;
        logic [7:0]         fsel;
        logic               two;
        logic [PC_W-1:0]    pc;
        logic [BANK_W-1:0]  bank;
        logic [DADDR_W-1:0] idx;
        logic               ext;
        logic [DADDR_W-1:0] addr;
        logic               bitv;
        logic               skip;
        logic [1:0]         nop_left;
        logic [PC_W-1:0]    pc_nx;
        logic [1:0]         ncyc;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic               dec_is_op, dec_pol, dec_banked, dec_two;
    logic [2:0]         dec_bsel;
    logic [7:0]         dec_fsel;
    logic [DADDR_W-1:0] ea_w;

    bitskip_decode #(
        .TW_MASK  (TW_MASK),
        .TW_MATCH (TW_MATCH)
    ) u_dec (
        .op_word     (instr_word),
        .follow_word (next_word),
        .is_op       (dec_is_op),
        .pol_set     (dec_pol),
        .bit_sel     (dec_bsel),
        .banked      (dec_banked),
        .fsel        (dec_fsel),
        .follow_two  (dec_two)
    );

    bitskip_addr #(
        .BANK_W (BANK_W)
    ) u_addr (
        .fsel   (ctx_q.fsel),
        .banked (ctx_q.banked),
        .ext_on (ctx_q.ext),
        .bank   (ctx_q.bank),
        .idx    (ctx_q.idx),
        .addr   (ea_w)
    );

    logic       skip_w;
    logic [1:0] nop_w;

    always_comb begin
        ctx_d  = ctx_q;
        skip_w = 1'b0;
        nop_w  = 2'd0;
        unique case (ctx_q.st)
            SEQ_IDLE: begin
                ctx_d.ph = PH_DECODE;
                if (start && dec_is_op) begin
                    ctx_d.st     = SEQ_EXEC;
                    ctx_d.pol    = dec_pol;
                    ctx_d.bsel   = dec_bsel;
                    ctx_d.banked = dec_banked;
                    ctx_d.fsel   = dec_fsel;
                    ctx_d.two    = dec_two;
                    ctx_d.pc     = pc_in;
                    ctx_d.bank   = bank_sel;
                    ctx_d.idx    = idx_ptr;
                    ctx_d.ext    = ext_mode;
                    ctx_d.bitv   = 1'b0;
                    ctx_d.skip   = 1'b0;
                end
            end
            SEQ_EXEC: begin
                ctx_d.ph = ctx_q.ph + 2'd1;
                unique case (ctx_q.ph)
                    PH_DECODE: ctx_d.addr = ea_w;
                    PH_READ:   ctx_d.bitv = rd_data[ctx_q.bsel];
                    PH_PROC: begin
                        skip_w         = ctx_q.pol ? ctx_q.bitv : ~ctx_q.bitv;
                        nop_w          = skip_w ? (ctx_q.two ? 2'd2 : 2'd1) : 2'd0;
                        ctx_d.skip     = skip_w;
                        ctx_d.nop_left = nop_w;
                        ctx_d.ncyc     = nop_w + 2'd1;
                        unique case (nop_w)
                            2'd0:    ctx_d.pc_nx = ctx_q.pc + STEP1;
                            2'd1:    ctx_d.pc_nx = ctx_q.pc + STEP2;
                            default: ctx_d.pc_nx = ctx_q.pc + STEP3;
                        endcase
                    end
                    default:   ctx_d.st = ctx_q.skip ? SEQ_NOP : SEQ_IDLE;
                endcase
            end
            SEQ_NOP: begin
                ctx_d.ph = ctx_q.ph + 2'd1;
                if (ctx_q.ph == PH_LAST) begin
                    ctx_d.nop_left = ctx_q.nop_left - 2'd1;
                    if (ctx_q.nop_left == 2'd1) begin
                        ctx_d.st = SEQ_IDLE;
                    end
                end
            end
            default: begin
                ctx_d.st = SEQ_IDLE;
                ctx_d.ph = PH_DECODE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        busy       = (ctx_q.st != SEQ_IDLE);
        q_phase    = ctx_q.ph;
        rd_en      = (ctx_q.st == SEQ_EXEC) && (ctx_q.ph == PH_READ);
        rd_addr    = ctx_q.addr;
        flush      = (ctx_q.st == SEQ_EXEC) && (ctx_q.ph == PH_LAST) && ctx_q.skip;
        done       = ((ctx_q.st == SEQ_EXEC) && (ctx_q.ph == PH_LAST) && !ctx_q.skip)
                   || ((ctx_q.st == SEQ_NOP) && (ctx_q.ph == PH_LAST)
                       && (ctx_q.nop_left == 2'd1));
        skip_taken = ctx_q.skip;
        pc_next    = ctx_q.pc_nx;
        cycles     = ctx_q.ncyc;
    end
endmodule

// File: rtl/bitskip_chk.sv
module bitskip_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [1:0] q_phase,
    input logic       rd_en,
    input logic       flush,
    input logic       done,
    input logic       skip_taken,
    input logic [1:0] cycles
);
    assert_rd_in_read_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (busy && q_phase == 2'd1));

    assert_phase_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q_phase != 2'd0) |-> (q_phase == $past(q_phase) + 2'd1));

    assert_flush_starts_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy && q_phase == 2'd0));

    assert_flush_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush && done));

    assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_plain_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !skip_taken) |-> (cycles == 2'd1));

    assert_skip_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skip_taken) |-> (cycles == 2'd2 || cycles == 2'd3));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !flush && !done && q_phase == 2'd0));
endmodule

bind bitskip_unit bitskip_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .q_phase    (q_phase),
    .rd_en      (rd_en),
    .flush      (flush),
    .done       (done),
    .skip_taken (skip_taken),
    .cycles     (cycles)
);

// File: tb/sim_bitskip_unit.sv
`timescale 1ns/1ps
module sim_bitskip_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr_word = '0;
    logic [15:0] next_word = '0;
    logic [20:0] pc_in = '0;
    logic [3:0]  bank_sel = '0;
    logic [11:0] idx_ptr = '0;
    logic        ext_mode = 1'b0;
    logic [11:0] rd_addr;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic        busy, flush, done, skip_taken;
    logic [1:0]  q_phase, cycles;
    logic [20:0] pc_next;

    logic [7:0] mem [4096];
    assign rd_data = mem[rd_addr];

    always #10 clk = ~clk;

    bitskip_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
        .next_word(next_word), .pc_in(pc_in), .bank_sel(bank_sel),
        .idx_ptr(idx_ptr), .ext_mode(ext_mode), .rd_addr(rd_addr),
        .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .q_phase(q_phase),
        .flush(flush), .done(done), .skip_taken(skip_taken),
        .pc_next(pc_next), .cycles(cycles)
    );

    int ntest = 0;
    int nfail = 0;
    int cyc = 0;
    bit fin = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        ntest++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct {
        logic [11:0] addr;
        logic        skip;
        logic [20:0] pc;
        logic [1:0]  ncyc;
        int          rd_at;
        int          fl_at;
        int          dn_at;
        string       tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [11:0] model_addr(input logic a, input logic [7:0] f,
                                               input logic [3:0] bsr,
                                               input logic [11:0] idx, input logic ext);
        if (a) return {bsr, f};
        if (ext && f < 8'h60) return idx + {4'h0, f};
        if (f >= 8'h60) return {4'hF, f};
        return {4'h0, f};
    endfunction

    // Monitor: pops expected items as the design reports them.
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            if (rd_en) begin
                if (sb.size() == 0) chk(0, "R10 unexpected read", 32'(rd_addr), 0);
                else begin
                    chk(rd_addr == sb[0].addr, {sb[0].tag, " rd_addr"}, 32'(rd_addr), 32'(sb[0].addr));
                    chk(cyc == sb[0].rd_at, "R6 read clock", cyc, sb[0].rd_at);
                end
            end
            if (flush) begin
                if (sb.size() == 0) chk(0, "R10 unexpected flush", 1, 0);
                else begin
                    chk(sb[0].skip, "R8 flush only on skip", 1, 32'(sb[0].skip));
                    chk(cyc == sb[0].fl_at, "R8 flush clock", cyc, sb[0].fl_at);
                end
            end
            if (done) begin
                if (sb.size() == 0) chk(0, "R10 unexpected done", 1, 0);
                else begin
                    chk(skip_taken == sb[0].skip, {sb[0].tag, " R2 skip"}, 32'(skip_taken), 32'(sb[0].skip));
                    chk(pc_next == sb[0].pc, {sb[0].tag, " pc_next"}, 32'(pc_next), 32'(sb[0].pc));
                    chk(cycles == sb[0].ncyc, {sb[0].tag, " cycles"}, 32'(cycles), 32'(sb[0].ncyc));
                    chk(cyc == sb[0].dn_at, {sb[0].tag, " done clock"}, cyc, sb[0].dn_at);
                    void'(sb.pop_front());
                end
            end
        end
    end

    // Driver: pushes the expected item and offers the operation.
    task automatic run_op(input logic set_t, input logic [2:0] b, input logic a,
                          input logic [7:0] f, input logic [3:0] bsr,
                          input logic [11:0] idx, input logic ext,
                          input logic [15:0] nxt, input logic [20:0] pc,
                          input logic bv, input bit poke, input string tag);
        exp_t e;
        logic [7:0] byte_v;
        logic two;
        int s;
        wait (sb.size() == 0);
        @(negedge clk);
        while (busy) @(negedge clk);
        e.addr = model_addr(a, f, bsr, idx, ext);
        byte_v = 8'(1 << b);
        if (!bv) byte_v = ~byte_v;
        mem[e.addr] = byte_v;
        e.skip = set_t ? bv : !bv;
        two = (nxt[15:12] == 4'hF);
        e.ncyc = e.skip ? (two ? 2'd3 : 2'd2) : 2'd1;
        e.pc = pc + 21'(2 * int'(e.ncyc));
        s = cyc + 1;
        e.rd_at = s + 1;
        e.fl_at = s + 3;
        e.dn_at = s + 4 * int'(e.ncyc) - 1;
        e.tag = tag;
        instr_word = {set_t ? 4'b1010 : 4'b1011, b, a, f};
        next_word = nxt;
        pc_in = pc;
        bank_sel = bsr;
        idx_ptr = idx;
        ext_mode = ext;
        start = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        instr_word = 16'h0000;
        pc_in = 21'h0;
        bank_sel = ~bsr;
        idx_ptr = ~idx;
        if (poke) begin
            instr_word = 16'hA155;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait (sb.size() == 0);
            repeat (4) begin
                @(negedge clk);
                chk(!busy && !rd_en, "R10 busy start ignored", 32'(busy), 0);
            end
        end
    endtask

    task automatic bad_op(input logic [15:0] w);
        wait (sb.size() == 0);
        @(negedge clk);
        while (busy) @(negedge clk);
        instr_word = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) begin
            chk(!busy && !rd_en && !done, "R1 foreign opcode ignored", 32'(busy), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            nfail++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37);
        repeat (3) @(negedge clk);
        chk(!busy && !rd_en && !flush && !done && q_phase == 2'd0,
            "R11 reset state", {busy, rd_en, flush, done, q_phase}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R7: clear form, bit set, low access window, no skip
        run_op(0, 3'd0, 0, 8'h10, 4'h0, 12'h000, 0, 16'h0000, 21'h000100, 1, 0, "R7 R4 plain");
        // R8 R4: clear form, bit clear, high window
        run_op(0, 3'd7, 0, 8'h80, 4'h0, 12'h000, 0, 16'h1234, 21'h000200, 0, 0, "R8 R4 high");
        // R9 R3: set form, banked, two-word follower
        run_op(1, 3'd3, 1, 8'h33, 4'h5, 12'h000, 0, 16'hF012, 21'h000300, 1, 0, "R9 R3 banked");
        // R2 R3: set form, bit clear, no skip
        run_op(1, 3'd5, 1, 8'hC4, 4'hF, 12'h000, 1, 16'hF000, 21'h000400, 0, 0, "R2 R3 set clear");
        // R5 R9: indexed at the upper edge of the window
        run_op(1, 3'd6, 0, 8'h5F, 4'h0, 12'h123, 1, 16'hFFFF, 21'h000500, 1, 0, "R5 R9 indexed");
        // R4: extended mode but field above window
        run_op(0, 3'd1, 0, 8'h60, 4'h0, 12'h400, 1, 16'hE000, 21'h000600, 0, 0, "R4 ext high");
        // R5: pointer sum wraps
        run_op(0, 3'd2, 0, 8'h20, 4'h0, 12'hFF0, 1, 16'h0000, 21'h000700, 1, 0, "R5 wrap");
        // R4: window edge without extended mode
        run_op(1, 3'd4, 0, 8'h5F, 4'h9, 12'h200, 0, 16'h0000, 21'h000800, 1, 0, "R4 edge");
        // R9: program counter wraps
        run_op(0, 3'd4, 1, 8'h01, 4'h2, 12'h000, 0, 16'hF100, 21'h1FFFFE, 0, 0, "R9 pc wrap");
        // R8: prefix 1110 is not a two-word follower
        run_op(1, 3'd2, 1, 8'h77, 4'h3, 12'h000, 0, 16'hEFFF, 21'h000900, 1, 0, "R8 one-word");
        // R1: foreign opcodes
        bad_op(16'hC1FF);
        bad_op(16'h9A00);
        // R10: start during an operation
        run_op(0, 3'd5, 1, 8'h44, 4'h1, 12'h000, 0, 16'hF000, 21'h000A00, 0, 1, "R10 busy");
        run_op(1, 3'd0, 0, 8'h02, 4'h0, 12'h000, 0, 16'h0000, 21'h000B00, 0, 1, "R10 plain busy");

        wait (sb.size() == 0);
        repeat (3) @(negedge clk);
        fin = 1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule